// File: doc/BRIEF.md
# Greedy Concurrent Action Scheduler

This block chooses which of a small set of guarded actions may update shared state in the same clock cycle. Each action arrives with a ready bit, a mask of the state registers it may read and a mask of the registers it may write. From the masks, the block classifies every pair of actions into one of three groups. A pair is independent when it touches no common state. A pair is ordered when it can be composed one way round. Any other pair clashes.

The block then goes through the actions from index 0 upward. It grants each ready action that clashes with none of the actions granted before it. The result is a fire vector. When a serial-mode input is set, the block grants only the lowest ready action, as a priority encoder would.

The block is combinational. Lower indices always win, so the block does not try to be fair. The masks are meant to come from static configuration. The pairwise classification is also brought out, so that the surrounding logic can use the ordering it implies.

Top module: `rsched_top`

## Requirements
- R1: For each pair i<j, the block reports code 2'b00 (independent) in bits [(i*N+j)*2 +: 2] of `pairRel` when three intersections are all empty: reads(i) with writes(j), reads(j) with writes(i), and writes(i) with writes(j).
- R2: A pair i<j that is not independent but has no common write bits gets code 2'b01 when reads(j)∩writes(i) is empty, meaning i composes before j. It gets code 2'b10 when reads(i)∩writes(j) is empty, meaning j composes before i.
- R3: Any other pair gets code 2'b11 (clash). In particular, any pair whose write masks overlap gets 2'b11.
- R4: Entries of `pairRel` with i ≥ j always read 2'b00.
- R5: With `serialMode` low, the lowest-index ready action always fires.
- R6: With `serialMode` low, a higher ready action k fires exactly when no action j<k that fires has code 2'b11 with k. The walk covers every index.
- R7: `fire` is always a subset of `ready`. When `ready` is zero, `fire` is zero.
- R8: With `serialMode` high, `fire` is exactly the lowest set bit of `ready`, so at most one bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ready | input | N (4) | Guard-true bit per action |
| readMask | input | N*M (32) | Read mask of action k in bits [k*M +: M] |
| writeMask | input | N*M (32) | Write mask of action k in bits [k*M +: M] |
| serialMode | input | 1 | 1 = fire only the lowest ready action |
| fire | output | N (4) | Granted actions |
| pairRel | output | N*N*2 (32) | Pair code for (i,j) in bits [(i*N+j)*2 +: 2] |

## Verification
There are no registers between the inputs and the outputs, so both `fire` and `pairRel` are due in the same cycle as the input change. The bench drives every new stimulus on the falling clock edge. It compares both outputs one nanosecond after the next rising edge, by which time the combinational paths have settled. It checks against a reference that classifies pairs by counting mask overlaps and performs the greedy walk with integer loops. It sweeps all 16 ready patterns in both modes, first over three hand-built mask sets (independent, crossed, ordered) and then over random ones.

// File: rtl/rsched_pkg.sv
package rsched_pkg;

  typedef enum logic [1:0] {
    REL_FREE   = 2'b00,
    REL_FIRST  = 2'b01,
    REL_SECOND = 2'b10,
    REL_CLASH  = 2'b11
  } pairRel_e;

  // strobes from the grant control toward the relation datapath
  typedef struct packed {
    logic forceSerial;
  } schedStrobe_t;

endpackage

// File: rtl/rsched_relation.sv
module rsched_relation
  import rsched_pkg::*;
#(
  parameter int N = 4,
  parameter int M = 8
) (
  input  logic [N*M-1:0]   readMask,
  input  logic [N*M-1:0]   writeMask,
  input  schedStrobe_t     strobe,
  output logic [N*N*2-1:0] pairRel,
  output logic [N*N-1:0]   conflictMat
);

  localparam int PairBits = 2;

  for (genvar gi = 0; gi < N; gi++) begin : g_row
    for (genvar gj = 0; gj < N; gj++) begin : g_col
      if (gi < gj) begin : g_upper
        logic rdJwrI, rdIwrJ, wrBoth;
        pairRel_e code;
        assign rdJwrI = |(readMask[gj*M +: M] & writeMask[gi*M +: M]);
        assign rdIwrJ = |(readMask[gi*M +: M] & writeMask[gj*M +: M]);
        assign wrBoth = |(writeMask[gi*M +: M] & writeMask[gj*M +: M]);
        always_comb begin
          if (wrBoth)                 code = REL_CLASH;
          else if (!rdJwrI && !rdIwrJ) code = REL_FREE;
          else if (!rdJwrI)           code = REL_FIRST;
          else if (!rdIwrJ)           code = REL_SECOND;
          else                        code = REL_CLASH;
        end
        assign pairRel[(gi*N+gj)*PairBits +: PairBits] = code;
        assign conflictMat[gi*N+gj] = (code == REL_CLASH) || strobe.forceSerial;
      end else if (gi == gj) begin : g_diag
        assign pairRel[(gi*N+gj)*PairBits +: PairBits] = REL_FREE;
        assign conflictMat[gi*N+gj] = 1'b0;
      end else begin : g_lower
        assign pairRel[(gi*N+gj)*PairBits +: PairBits] = REL_FREE;
        assign conflictMat[gi*N+gj] = conflictMat[gj*N+gi];
      end
    end
  end

endmodule

// File: rtl/rsched_grant.sv
module rsched_grant
  import rsched_pkg::*;
#(
  parameter int N = 4
) (
  input  logic [N-1:0]   ready,
  input  logic           serialMode,
  input  logic [N*N-1:0] conflictMat,
  output schedStrobe_t   strobe,
  output logic [N-1:0]   fire
);

  assign strobe.forceSerial = serialMode;

  always_comb begin
    logic ok;
    fire = '0;
    for (int k = 0; k < N; k++) begin
      ok = ready[k];
      for (int j = 0; j < N; j++) begin
        if (j < k && fire[j] && conflictMat[j*N+k]) ok = 1'b0;
      end
      fire[k] = ok;
    end
  end

  always_comb begin
    logic seen;
    // R7
    fire_subset_chk: assert ((fire & ~ready) == '0)
      else $error("fire outside ready");
    seen = 1'b0;
    for (int k = 0; k < N; k++) begin
      if (ready[k] && !seen) begin
        // R5
        lowest_fires_chk: assert (fire[k])
          else $error("lowest ready action not granted");
        seen = 1'b1;
      end
    end
    for (int a = 0; a < N; a++) begin
      for (int b = 0; b < N; b++) begin
        if (a < b && fire[a] && fire[b]) begin
          // R6
          no_clash_pair_chk: assert (!conflictMat[a*N+b])
            else $error("two clashing actions granted");
        end
      end
    end
  end

endmodule

// File: rtl/rsched_top.sv
module rsched_top
  import rsched_pkg::*;
#(
  parameter int N = 4,
  parameter int M = 8
) (
  input  logic [N-1:0]     ready,
  input  logic [N*M-1:0]   readMask,
  input  logic [N*M-1:0]   writeMask,
  input  logic             serialMode,
  output logic [N-1:0]     fire,
  output logic [N*N*2-1:0] pairRel
);

  schedStrobe_t   strobe;
  logic [N*N-1:0] conflictMat;

  rsched_relation #(.N(N), .M(M)) i_relation (
    .readMask   (readMask),
    .writeMask  (writeMask),
    .strobe     (strobe),
    .pairRel    (pairRel),
    .conflictMat(conflictMat)
  );

  rsched_grant #(.N(N)) i_grant (
    .ready      (ready),
    .serialMode (serialMode),
    .conflictMat(conflictMat),
    .strobe     (strobe),
    .fire       (fire)
  );

  always_comb begin
    // R8
    serial_onehot_chk: assert (!serialMode || $onehot0(fire))
      else $error("more than one grant in serial mode");
    for (int i = 0; i < N; i++) begin
      for (int j = 0; j < N; j++) begin
        if (i < j && |(writeMask[i*M +: M] & writeMask[j*M +: M])) begin
          // R3
          write_overlap_chk: assert (pairRel[(i*N+j)*2 +: 2] == 2'b11)
            else $error("write overlap not flagged as clash");
        end
        if (i >= j) begin
          // R4
          lower_zero_chk: assert (pairRel[(i*N+j)*2 +: 2] == 2'b00)
            else $error("non-upper pair entry not zero");
        end
      end
    end
  end

endmodule

// File: tb/test_rsched_top.sv
`timescale 1ns/1ps
module test_rsched_top;

  localparam int N = 4;
  localparam int M = 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [N-1:0]     ready;
  logic [N*M-1:0]   readMask, writeMask;
  logic             serialMode;
  logic [N-1:0]     fire;
  logic [N*N*2-1:0] pairRel;

  logic [M-1:0] rdM [N];
  logic [M-1:0] wrM [N];

  int nTests = 0;
  int nFail  = 0;

  rsched_top #(.N(N), .M(M)) i_rsched_top (
    .ready(ready), .readMask(readMask), .writeMask(writeMask),
    .serialMode(serialMode), .fire(fire), .pairRel(pairRel)
  );

  function automatic int overlap(logic [M-1:0] a, logic [M-1:0] b);
    int c = 0;
    for (int t = 0; t < M; t++) if (a[t] && b[t]) c++;
    return c;
  endfunction

  function automatic logic [1:0] refRel(int i, int j);
    int rjwi, riwj, ww;
    if (i >= j) return 2'b00;
    rjwi = overlap(rdM[j], wrM[i]);
    riwj = overlap(rdM[i], wrM[j]);
    ww   = overlap(wrM[i], wrM[j]);
    if (ww > 0) return 2'b11;
    if (rjwi == 0 && riwj == 0) return 2'b00;
    if (rjwi == 0) return 2'b01;
    if (riwj == 0) return 2'b10;
    return 2'b11;
  endfunction

  function automatic logic [N-1:0] refFire(logic [N-1:0] en, logic ser);
    logic [N-1:0] g = '0;
    for (int k = 0; k < N; k++) begin
      bit ok = en[k];
      for (int j = 0; j < k; j++) begin
        if (g[j] && (ser || refRel(j, k) == 2'b11)) ok = 0;
      end
      g[k] = ok;
    end
    return g;
  endfunction

  task automatic check(bit good, string tag, int act, int exp);
    nTests++;
    if (!good) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic loadMasks();
    for (int k = 0; k < N; k++) begin
      readMask[k*M +: M]  = rdM[k];
      writeMask[k*M +: M] = wrM[k];
    end
  endtask

  task automatic applyAndCheck(logic [N-1:0] en, logic ser);
    logic [N-1:0] expF;
    int low;
    @(negedge clk);
    ready = en;
    serialMode = ser;
    loadMasks();
    @(posedge clk);
    #1;
    for (int i = 0; i < N; i++) begin
      for (int j = 0; j < N; j++) begin
        logic [1:0] e = refRel(i, j);
        logic [1:0] a = pairRel[(i*N+j)*2 +: 2];
        string tag = (i >= j) ? "R4" : (e == 2'b00) ? "R1" : (e == 2'b11) ? "R3" : "R2";
        check(a == e, tag, a, e);
      end
    end
    expF = refFire(en, ser);
    check(fire == expF, ser ? "R8" : "R6", fire, expF);
    check((fire & ~en) == '0 && (en != '0 || fire == '0), "R7", fire, en & expF);
    low = -1;
    for (int k = N - 1; k >= 0; k--) if (en[k]) low = k;
    if (low >= 0 && !ser) check(fire[low], "R5", fire, expF);
  endtask

  initial begin
    #400000;
    nTests++;
    nFail++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    ready = '0; serialMode = 1'b0;
    for (int k = 0; k < N; k++) begin rdM[k] = '0; wrM[k] = '0; end
    loadMasks();
    #3;
    check(fire == '0, "R7", fire, 0);
    check(pairRel == '0, "R1", pairRel, 0);

    // set 1: (0,1) disjoint, (2,3) crossed read/write
    rdM[0] = 8'h01; wrM[0] = 8'h02;
    rdM[1] = 8'h04; wrM[1] = 8'h08;
    wrM[2] = 8'h10; rdM[2] = 8'h20;
    wrM[3] = 8'h20; rdM[3] = 8'h10;
    for (int e = 0; e < 16; e++) for (int s = 0; s < 2; s++) applyAndCheck(e[N-1:0], s[0]);
    check(pairRel[(0*N+1)*2 +: 2] == 2'b00, "R1", pairRel[(0*N+1)*2 +: 2], 0);
    check(pairRel[(2*N+3)*2 +: 2] == 2'b11, "R3", pairRel[(2*N+3)*2 +: 2], 3);

    // set 2: action 0 reads y writes x, action 1 reads and writes y
    rdM[0] = 8'h02; wrM[0] = 8'h01;
    rdM[1] = 8'h02; wrM[1] = 8'h02;
    rdM[2] = 8'h01; wrM[2] = 8'h40;
    rdM[3] = 8'h00; wrM[3] = 8'h40;
    for (int e = 0; e < 16; e++) for (int s = 0; s < 2; s++) applyAndCheck(e[N-1:0], s[0]);
    check(pairRel[(0*N+1)*2 +: 2] == 2'b01, "R2", pairRel[(0*N+1)*2 +: 2], 1);
    check(pairRel[(2*N+3)*2 +: 2] == 2'b11, "R3", pairRel[(2*N+3)*2 +: 2], 3);

    // set 3: reverse order composability
    rdM[0] = 8'h01; wrM[0] = 8'h01;
    rdM[1] = 8'h04; wrM[1] = 8'h08;
    rdM[2] = 8'h00; wrM[2] = 8'h80;
    rdM[3] = 8'h00; wrM[3] = 8'h00;
    rdM[2][3] = 1'b1;
    for (int e = 0; e < 16; e++) for (int s = 0; s < 2; s++) applyAndCheck(e[N-1:0], s[0]);

    // random mask sets
    for (int r = 0; r < 30; r++) begin
      for (int k = 0; k < N; k++) begin
        rdM[k] = M'($urandom) & M'($urandom);
        wrM[k] = M'($urandom) & M'($urandom) & M'($urandom);
      end
      for (int e = 0; e < 16; e++) for (int s = 0; s < 2; s++) applyAndCheck(e[N-1:0], s[0]);
    end

    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule